// File: doc/BRIEF.md
# FFT Output Exponent Normaliser

This block takes 16-bit words leaving a block-floating-point FFT and rescales each of them so that all words share one binary-point position. Every word arrives with a 2-bit tag that places its binary point relative to a 5-bit two's complement global weighting value. The block adds the tag straight onto the global value to form the word's exponent. It subtracts that exponent from a programmable universal exponent and uses the result as the distance of an arithmetic right shift.

The tag is added as a plain unsigned number and is not first decoded into its signed weighting. For that reason the universal exponent is programmed one above its nominal value, which is log2(N) for an N-point transform. An N = 1024 transform therefore uses 11. A negative global value traps the shift to its maximum of 15 places. A difference that would need a left shift is clamped to zero and flagged.

Real and imaginary samples can share the block on alternate cycles. A sample marked as the imaginary phase reuses the shift of the most recent real-phase sample. There is one registered pipeline stage, and a valid bit and the phase bit travel alongside the data.

Top module: `nrm_exp_norm`

## Requirements
- R1: During reset and after it, until the first valid sample, out_valid, out_phase, out_data, out_shift and out_sat are all 0.
- R2: out_valid equals in_valid one clock later. On a cycle with in_valid low, out_phase, out_data, out_shift and out_sat hold their previous values.
- R3: For a real-phase sample (in_phase = 0) with non-negative gwr_i, the word exponent is gwr_i plus in_tag, with the tag read as an unsigned value 0 to 3. out_shift is uexp_i minus that exponent whenever the difference lies in 0..15.
- R4: out_data is in_data arithmetically shifted right by out_shift places, with the sign bit filling the vacated upper bits.
- R5: A real-phase sample whose gwr_i has bit 4 set (a negative value) gets out_shift = 15 and out_sat = 0, whatever uexp_i and in_tag are.
- R6: When the difference exceeds 15 and gwr_i is non-negative, out_shift is 15 and out_sat is 0.
- R7: When the difference is negative, out_shift is 0, out_sat is 1, and out_data equals in_data unchanged.
- R8: An imaginary-phase sample (in_phase = 1) uses the out_shift and out_sat of the most recent valid real-phase sample, and its own in_tag and gwr_i have no effect. out_phase carries in_phase. Real-phase cycles with in_valid low do not change the shift that is held for the imaginary phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| uexp_i | input | 5 | Universal exponent, nominal value plus one |
| gwr_i | input | 5 | Global weighting value, two's complement |
| in_valid | input | 1 | Input sample valid |
| in_phase | input | 1 | 0 = real sample, 1 = imaginary sample |
| in_tag | input | 2 | Word tag of the sample |
| in_data | input | 16 | Sample, two's complement |
| out_valid | output | 1 | Output sample valid |
| out_phase | output | 1 | Phase of the output sample |
| out_data | output | 16 | Rescaled sample |
| out_shift | output | 4 | Right-shift distance that was applied |
| out_sat | output | 1 | A left shift was needed and was clamped to zero |

## Verification
Every result (out_valid, out_phase, out_data, out_shift and out_sat) is due at the first rising edge after the sample is presented. The shift held for the imaginary phase takes effect on the edge that registers the following imaginary sample. The bench changes inputs on falling edges and reads the outputs 1 ns after the next rising edge, so each check looks at exactly one registered result. Idle cycles are checked at the following edge by confirming that the data outputs have not moved. The held shift is checked by sending an imaginary sample after idle real-phase cycles.

// File: rtl/nrm_pkg.sv
package nrm_pkg;
  typedef enum logic [0:0] {
    PH_RE = 1'b0,
    PH_IM = 1'b1
  } nrm_phase_e;
endpackage

// File: rtl/nrm_shift_calc.sv
module nrm_shift_calc #(
  parameter int DATA_W = 16,
  parameter int GWR_W  = 5,
  parameter int TAG_W  = 2,
  parameter int UEXP_W = 5
) (
  input  logic [UEXP_W-1:0]         uexp,
  input  logic [GWR_W-1:0]          gwr,
  input  logic [TAG_W-1:0]          tag,
  output logic [$clog2(DATA_W)-1:0] shift,
  output logic                      sat,
  output logic                      trap,
  output logic                      clip
);
  localparam int SH_W  = $clog2(DATA_W);
  localparam int EXP_W = GWR_W + 1;
  localparam int DIF_W = ((UEXP_W > EXP_W) ? UEXP_W : EXP_W) + 2;
  localparam logic signed [DIF_W-1:0] MAX_D = DIF_W'(DATA_W - 1);

  // word exponent: magnitude of the global value plus the raw tag
  function automatic logic [EXP_W-1:0] word_exp(input logic [GWR_W-1:0] g,
                                                 input logic [TAG_W-1:0] t);
    return EXP_W'(g[GWR_W-2:0]) + EXP_W'(t);
  endfunction

  function automatic logic signed [DIF_W-1:0] exp_diff(input logic [UEXP_W-1:0] u,
                                                        input logic [EXP_W-1:0]  e);
    return $signed(DIF_W'(u)) - $signed(DIF_W'(e));
  endfunction

  logic [EXP_W-1:0]        wexp;
  logic signed [DIF_W-1:0] diff;

  assign wexp = word_exp(gwr, tag);
  assign diff = exp_diff(uexp, wexp);
  assign trap = gwr[GWR_W-1];
  assign clip = !trap && (diff > MAX_D);

  always_comb begin
    sat   = 1'b0;
    shift = '0;
    if (trap) begin
      shift = '1;
    end else if (diff < 0) begin
      sat = 1'b1;
    end else if (clip) begin
      shift = '1;
    end else begin
      shift = diff[SH_W-1:0];
    end
  end
endmodule

// File: rtl/nrm_phase_hold.sv
module nrm_phase_hold #(
  parameter int SH_W        = 4,
  parameter bit SHARE_SHIFT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            in_phase,
  input  logic [SH_W-1:0] calc_shift,
  input  logic            calc_sat,
  output logic [SH_W-1:0] sel_shift,
  output logic            sel_sat,
  output logic            use_held
);
  generate
    if (SHARE_SHIFT) begin : g_share
      logic [SH_W-1:0] held_shift;
      logic            held_sat;
      logic            real_load;

      assign real_load = in_valid && (in_phase == nrm_pkg::PH_RE);
      assign use_held  = (in_phase == nrm_pkg::PH_IM);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          held_shift <= '0;
          held_sat   <= 1'b0;
        end else if (real_load) begin
          held_shift <= calc_shift;
          held_sat   <= calc_sat;
        end
      end

      assign sel_shift = use_held ? held_shift : calc_shift;
      assign sel_sat   = use_held ? held_sat   : calc_sat;
    end else begin : g_each
      logic unused_ok;
      assign unused_ok = &{1'b0, clk, rst_n, in_valid, in_phase};
      assign use_held  = 1'b0;
      assign sel_shift = calc_shift;
      assign sel_sat   = calc_sat;
    end
  endgenerate
endmodule

// File: rtl/nrm_barrel.sv
module nrm_barrel #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0]         din,
  input  logic [$clog2(DATA_W)-1:0] sh,
  output logic [DATA_W-1:0]         dout
);
  localparam int SH_W = $clog2(DATA_W);

  logic [DATA_W-1:0] stage [SH_W+1];

  assign stage[0] = din;

  generate
    for (genvar k = 0; k < SH_W; k++) begin : g_stage
      assign stage[k+1] = sh[k] ? DATA_W'($signed(stage[k]) >>> (1 << k)) : stage[k];
    end
  endgenerate

  assign dout = stage[SH_W];
endmodule

// File: rtl/nrm_exp_norm.sv
module nrm_exp_norm #(
  parameter int DATA_W      = 16,
  parameter int GWR_W       = 5,
  parameter int TAG_W       = 2,
  parameter int UEXP_W      = 5,
  parameter bit SHARE_SHIFT = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [UEXP_W-1:0]         uexp_i,
  input  logic [GWR_W-1:0]          gwr_i,
  input  logic                      in_valid,
  input  logic                      in_phase,
  input  logic [TAG_W-1:0]          in_tag,
  input  logic [DATA_W-1:0]         in_data,
  output logic                      out_valid,
  output logic                      out_phase,
  output logic [DATA_W-1:0]         out_data,
  output logic [$clog2(DATA_W)-1:0] out_shift,
  output logic                      out_sat
);
  localparam int SH_W = $clog2(DATA_W);

  // named internal events for the checker
  logic [SH_W-1:0]   calc_shift;
  logic              calc_sat;
  logic              sh_trap;
  logic              sh_clip;
  logic [SH_W-1:0]   sel_shift;
  logic              sel_sat;
  logic              use_held;
  logic [DATA_W-1:0] shifted;

  nrm_shift_calc #(
    .DATA_W(DATA_W), .GWR_W(GWR_W), .TAG_W(TAG_W), .UEXP_W(UEXP_W)
  ) u_calc (
    .uexp (uexp_i),
    .gwr  (gwr_i),
    .tag  (in_tag),
    .shift(calc_shift),
    .sat  (calc_sat),
    .trap (sh_trap),
    .clip (sh_clip)
  );

  nrm_phase_hold #(
    .SH_W(SH_W), .SHARE_SHIFT(SHARE_SHIFT)
  ) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_phase  (in_phase),
    .calc_shift(calc_shift),
    .calc_sat  (calc_sat),
    .sel_shift (sel_shift),
    .sel_sat   (sel_sat),
    .use_held  (use_held)
  );

  nrm_barrel #(.DATA_W(DATA_W)) u_barrel (
    .din (in_data),
    .sh  (sel_shift),
    .dout(shifted)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_phase <= 1'b0;
      out_data  <= '0;
      out_shift <= '0;
      out_sat   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_phase <= in_phase;
        out_data  <= shifted;
        out_shift <= sel_shift;
        out_sat   <= sel_sat;
      end
    end
  end
endmodule

// File: rtl/nrm_exp_norm_chk.sv
module nrm_exp_norm_chk #(
  parameter int DATA_W = 16,
  parameter int GWR_W  = 5
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic                      in_phase,
  input logic [DATA_W-1:0]         in_data,
  input logic [GWR_W-1:0]          gwr_i,
  input logic                      out_valid,
  input logic                      out_phase,
  input logic [DATA_W-1:0]         out_data,
  input logic [$clog2(DATA_W)-1:0] out_shift,
  input logic                      out_sat,
  input logic                      sh_trap,
  input logic                      use_held
);
  localparam int SH_W = $clog2(DATA_W);
  localparam logic [SH_W-1:0] SH_ALL = '1;

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_data) && $stable(out_shift)));

  // R5
  trap_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !use_held && sh_trap) |=> (out_shift == SH_ALL && !out_sat));

  // R7
  sat_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && out_sat) |=> (out_sat |-> out_shift == '0));

  // R7
  sat_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sat) |-> (out_data == $past(in_data)));

  // R4
  sign_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_shift == SH_ALL) |-> (out_data == {DATA_W{$past(in_data[DATA_W-1])}}));

  // R8
  pair_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_phase && in_valid && in_phase) |=> (out_shift == $past(out_shift) && out_sat == $past(out_sat)));

  // R8
  phase_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_phase == $past(in_phase)));

  // R3
  gwr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sh_trap |-> gwr_i[GWR_W-1]);
endmodule

bind nrm_exp_norm nrm_exp_norm_chk #(.DATA_W(DATA_W), .GWR_W(GWR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_phase (in_phase),
  .in_data  (in_data),
  .gwr_i    (gwr_i),
  .out_valid(out_valid),
  .out_phase(out_phase),
  .out_data (out_data),
  .out_shift(out_shift),
  .out_sat  (out_sat),
  .sh_trap  (sh_trap),
  .use_held (use_held)
);

// File: tb/tb_nrm_exp_norm.sv
`timescale 1ns/1ps
module tb_nrm_exp_norm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  uexp_i = '0;
  logic [4:0]  gwr_i = '0;
  logic        in_valid = 1'b0;
  logic        in_phase = 1'b0;
  logic [1:0]  in_tag = '0;
  logic [15:0] in_data = '0;
  logic        out_valid, out_phase, out_sat;
  logic [15:0] out_data;
  logic [3:0]  out_shift;

  int checks = 0;
  int errors = 0;
  int ref_shift = 0;
  int ref_sat = 0;
  int held_shift = 0;
  int held_sat = 0;

  always #5 clk = ~clk;

  nrm_exp_norm dut (
    .clk(clk), .rst_n(rst_n), .uexp_i(uexp_i), .gwr_i(gwr_i),
    .in_valid(in_valid), .in_phase(in_phase), .in_tag(in_tag), .in_data(in_data),
    .out_valid(out_valid), .out_phase(out_phase), .out_data(out_data),
    .out_shift(out_shift), .out_sat(out_sat)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // independent model of the shift rule
  task automatic model(input int u, input int g, input int t);
    int d;
    if (g >= 16) begin
      ref_shift = 15; ref_sat = 0;
    end else begin
      d = u - (g + t);
      if (d < 0)       begin ref_shift = 0;  ref_sat = 1; end
      else if (d > 15) begin ref_shift = 15; ref_sat = 0; end
      else             begin ref_shift = d;  ref_sat = 0; end
    end
  endtask

  function automatic int shr(input logic [15:0] d, input int s);
    logic signed [15:0] v;
    v = $signed(d) >>> s;
    return int'(v);
  endfunction

  // present one real sample, check its result one edge later
  task automatic send_real(input string req, input int u, input int g, input int t,
                           input logic [15:0] d);
    @(negedge clk);
    uexp_i = 5'(u); gwr_i = 5'(g); in_tag = 2'(t); in_data = d;
    in_valid = 1'b1; in_phase = 1'b0;
    model(u, g, t);
    held_shift = ref_shift; held_sat = ref_sat;
    @(posedge clk); #1;
    check({req, " valid"}, int'(out_valid), 1);
    check({req, " phase"}, int'(out_phase), 0);
    check({req, " shift"}, int'(out_shift), ref_shift);
    check({req, " sat"},   int'(out_sat), ref_sat);
    check({req, " data"},  int'($signed(out_data)), shr(d, ref_shift));
  endtask

  task automatic send_imag(input string req, input int g, input int t, input logic [15:0] d);
    @(negedge clk);
    gwr_i = 5'(g); in_tag = 2'(t); in_data = d;
    in_valid = 1'b1; in_phase = 1'b1;
    @(posedge clk); #1;
    check({req, " valid"}, int'(out_valid), 1);
    check({req, " phase"}, int'(out_phase), 1);
    check({req, " shift"}, int'(out_shift), held_shift);
    check({req, " sat"},   int'(out_sat), held_sat);
    check({req, " data"},  int'($signed(out_data)), shr(d, held_shift));
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 valid", int'(out_valid), 0);
    check("R1 phase", int'(out_phase), 0);
    check("R1 data",  int'(out_data), 0);
    check("R1 shift", int'(out_shift), 0);
    check("R1 sat",   int'(out_sat), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after release", int'(out_valid), 0);
  endtask

  task automatic t_basic;
    send_real("R3 R4 n1024", 11, 2, 1, 16'h4000);
    send_real("R3 R4 negative", 11, 0, 0, 16'h8000);
    send_real("R3 R4 mixed", 9, 3, 3, 16'hA5C3);
    send_real("R3 zero shift", 6, 4, 2, 16'h7FFF);
  endtask

  task automatic t_trap;
    send_real("R5 trap neg", 11, 5'b11110, 2, 16'h8001);
    send_real("R5 trap pos", 0, 5'b10000, 0, 16'h7FFF);
  endtask

  task automatic t_clip;
    send_real("R6 clip", 31, 0, 0, 16'h9000);
  endtask

  task automatic t_sat;
    send_real("R7 sat", 2, 3, 2, 16'hC123);
    check("R7 unshifted", int'(out_data), 16'hC123);
  endtask

  task automatic t_pair;
    send_real("R8 real", 11, 2, 1, 16'h1234);
    send_imag("R8 imag trap ignored", 5'b11111, 3, 16'h8000);
    send_real("R8 real sat", 1, 2, 0, 16'h4321);
    send_imag("R8 imag sat held", 0, 0, 16'hF00F);
  endtask

  task automatic t_idle;
    logic [15:0] last;
    send_real("R2 before idle", 10, 1, 1, 16'h7000);
    last = out_data;
    @(negedge clk);
    in_valid = 1'b0; in_phase = 1'b0; gwr_i = 5'd0; in_tag = 2'd0; uexp_i = 5'd0;
    in_data = 16'h0F0F;
    @(posedge clk); #1;
    check("R2 idle valid", int'(out_valid), 0);
    check("R2 idle data", int'(out_data), int'(last));
    check("R2 idle shift", int'(out_shift), held_shift);
    // idle real-phase cycle must not have altered the held shift
    send_imag("R8 after idle", 0, 0, 16'h7000);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_trap();
    t_clip();
    t_sat();
    t_pair();
    t_idle();
    @(negedge clk); in_valid = 1'b0;
    repeat (2) @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule